// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It combines two independent predictors. The first is a table of 2-bit saturating counters addressed by the global branch history. The second is a two-level local predictor: the branch PC selects a per-branch history register, and that history addresses its own table of 2-bit counters. A third table of 2-bit counters, also addressed by the global history, acts as a chooser. It decides which of the two component predictions is passed on as the final answer, and it learns which component has been right more often.

The lookup port is purely combinational. From a PC and the current global history it returns the final prediction and both component predictions. The front end keeps the component predictions with the branch. When the branch resolves, it presents them on the update port together with the PC, the history used at lookup and the real outcome. The update is applied at the next rising clock edge. A lookup made in the same cycle as an update therefore always sees the state from before that update. Speculative history tracking is the job of the logic around this block.

Top module: `tournament_bp`

## Requirements
- R1: While `rst_n` is low, every global, local and chooser counter is set to 1 and every local history register is set to 0. After reset, every lookup therefore returns 0 on `lk_taken`, `lk_glob_pred` and `lk_loc_pred`.
- R2: `lk_glob_pred` is 1 when the global counter at index `lk_ghist` holds 2 or more.
- R3: The local history register used by a lookup is entry `lk_pc[LHT_W+1:2]`. Its low `LPRED_W` bits address the local counter table, and `lk_loc_pred` is 1 when that counter holds 2 or more.
- R4: On an accepted update, the global counter at `up_ghist` and the local counter addressed by the branch's current local history each step by +1 when `up_taken` is 1 and by -1 when it is 0. Counters saturate at 0 and 3.
- R5: On an accepted update, the local history register at `up_pc[LHT_W+1:2]` shifts left by one and takes `up_taken` into bit 0. The oldest bit is dropped.
- R6: `lk_taken` equals `lk_glob_pred` when the chooser counter at `lk_ghist` holds 2 or more. Otherwise it equals `lk_loc_pred`.
- R7: The chooser counter at `up_ghist` changes only when `up_glob_pred` differs from `up_loc_pred`. It steps +1 when `up_glob_pred` equals `up_taken` and -1 otherwise, saturating at 0 and 3.
- R8: A lookup in the same cycle as an update to the same entries returns the values held before that update.
- R9: When `up_valid` is 0, the update fields have no effect on any table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | PC_W | Branch PC for lookup |
| lk_ghist | input | GHIST_W | Global history for lookup |
| lk_taken | output | 1 | Final direction prediction |
| lk_glob_pred | output | 1 | Global component prediction |
| lk_loc_pred | output | 1 | Local component prediction |
| up_valid | input | 1 | Update strobe |
| up_pc | input | PC_W | PC of the resolved branch |
| up_ghist | input | GHIST_W | Global history used at its lookup |
| up_taken | input | 1 | Resolved outcome |
| up_glob_pred | input | 1 | Saved global component prediction |
| up_loc_pred | input | 1 | Saved local component prediction |

## Verification
Four properties are checked on every cycle. The final prediction must always be one of the two component predictions. A global counter read back one cycle after an update must have stepped exactly once, with saturation, or must not have changed if the update was idle. A local history read back after an update must show the one-bit shift. A chooser counter must stay unchanged when the saved component predictions agreed.

Other behaviours can only be shown by the bench's scenarios, which run against a behavioural model:
- how the chooser swings between the components after disagreements,
- how the local counters train through the history indirection,
- that the reset values are correct,
- that a lookup racing an update to the same entry sees the old values.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_NT = 2'd1;
  localparam ctr2_t CTR_MAX     = 2'd3;
  localparam ctr2_t CTR_MIN     = 2'd0;

  // One saturating training step toward the given direction.
  function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
    ctr2_t r;
    if (up) r = (c == CTR_MAX) ? CTR_MAX : c + 2'd1;
    else    r = (c == CTR_MIN) ? CTR_MIN : c - 2'd1;
    return r;
  endfunction

  // Upper half of the counter range means taken (or "global" for the chooser).
  function automatic logic ctr_high(input ctr2_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table
  import tbp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_idx,
  output ctr2_t            ra_val,
  input  logic [IDX_W-1:0] rb_idx,
  output ctr2_t            rb_val,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic             w_dir
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t mem [DEPTH];

  assign ra_val = mem[ra_idx];
  assign rb_val = mem[rb_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_WEAK_NT;
    end else if (we) begin
      mem[w_idx] <= ctr_step(mem[w_idx], w_dir);
    end
  end
endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
  parameter int IDX_W  = 6,
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [HIST_W-1:0] ra_hist,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [HIST_W-1:0] rb_hist,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic              w_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] mem [DEPTH];

  assign ra_hist = mem[ra_idx];
  assign rb_hist = mem[rb_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[w_idx] <= {mem[w_idx][HIST_W-2:0], w_bit};
    end
  end
endmodule

// File: rtl/tournament_bp.sv
module tournament_bp
  import tbp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int GHIST_W = 8,
  parameter int LHT_W   = 6,
  parameter int LHIST_W = 8,
  parameter int LPRED_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PC_W-1:0]    lk_pc,
  input  logic [GHIST_W-1:0] lk_ghist,
  output logic               lk_taken,
  output logic               lk_glob_pred,
  output logic               lk_loc_pred,
  input  logic               up_valid,
  input  logic [PC_W-1:0]    up_pc,
  input  logic [GHIST_W-1:0] up_ghist,
  input  logic               up_taken,
  input  logic               up_glob_pred,
  input  logic               up_loc_pred
);
  localparam int PC_LO = 2;
  localparam int PC_HI = LHT_W + PC_LO - 1;

  // Named internal events, brought out for the checker.
  logic [LHT_W-1:0]   lk_lht_idx, up_lht_idx;
  logic [LHIST_W-1:0] lk_lhist, up_lhist;
  logic [LPRED_W-1:0] lk_lpt_idx, up_lpt_idx;
  ctr2_t              lk_gctr, lk_lctr, lk_cctr;
  ctr2_t              up_gctr, up_lctr, up_cctr;
  logic               up_disagree, up_glob_right, cho_we;

  assign lk_lht_idx    = lk_pc[PC_HI:PC_LO];
  assign up_lht_idx    = up_pc[PC_HI:PC_LO];
  assign lk_lpt_idx    = lk_lhist[LPRED_W-1:0];
  assign up_lpt_idx    = up_lhist[LPRED_W-1:0];
  assign up_disagree   = up_glob_pred ^ up_loc_pred;
  assign up_glob_right = (up_glob_pred == up_taken);
  assign cho_we        = up_valid & up_disagree;

  // Global component: counters addressed by global history.
  tbp_ctr_table #(.IDX_W(GHIST_W)) u_glob (
    .clk, .rst_n,
    .ra_idx(lk_ghist), .ra_val(lk_gctr),
    .rb_idx(up_ghist), .rb_val(up_gctr),
    .we(up_valid), .w_idx(up_ghist), .w_dir(up_taken)
  );

  // Local first level: per-branch history registers.
  tbp_hist_table #(.IDX_W(LHT_W), .HIST_W(LHIST_W)) u_lht (
    .clk, .rst_n,
    .ra_idx(lk_lht_idx), .ra_hist(lk_lhist),
    .rb_idx(up_lht_idx), .rb_hist(up_lhist),
    .we(up_valid), .w_idx(up_lht_idx), .w_bit(up_taken)
  );

  // Local second level: counters addressed by the local history.
  tbp_ctr_table #(.IDX_W(LPRED_W)) u_lpt (
    .clk, .rst_n,
    .ra_idx(lk_lpt_idx), .ra_val(lk_lctr),
    .rb_idx(up_lpt_idx), .rb_val(up_lctr),
    .we(up_valid), .w_idx(up_lpt_idx), .w_dir(up_taken)
  );

  // Chooser: high half favours the global component.
  tbp_ctr_table #(.IDX_W(GHIST_W)) u_cho (
    .clk, .rst_n,
    .ra_idx(lk_ghist), .ra_val(lk_cctr),
    .rb_idx(up_ghist), .rb_val(up_cctr),
    .we(cho_we), .w_idx(up_ghist), .w_dir(up_glob_right)
  );

  assign lk_glob_pred = ctr_high(lk_gctr);
  assign lk_loc_pred  = ctr_high(lk_lctr);
  assign lk_taken     = ctr_high(lk_cctr) ? lk_glob_pred : lk_loc_pred;

endmodule

// File: rtl/tbp_checker.sv
module tbp_checker
  import tbp_pkg::*;
#(
  parameter int GHIST_W = 8,
  parameter int LHT_W   = 6,
  parameter int LHIST_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [GHIST_W-1:0] lk_ghist,
  input logic               lk_taken,
  input logic               lk_glob_pred,
  input logic               lk_loc_pred,
  input logic               up_valid,
  input logic [GHIST_W-1:0] up_ghist,
  input logic               up_taken,
  input logic               up_glob_pred,
  input logic               up_loc_pred,
  input logic [LHT_W-1:0]   lk_lht_idx,
  input logic [LHT_W-1:0]   up_lht_idx,
  input logic [LHIST_W-1:0] lk_lhist,
  input logic [LHIST_W-1:0] up_lhist,
  input ctr2_t              lk_gctr,
  input ctr2_t              up_gctr,
  input ctr2_t              lk_cctr,
  input ctr2_t              up_cctr
);
  p_pick_member_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_taken == lk_glob_pred) || (lk_taken == lk_loc_pred));

  p_glob_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(up_valid && up_taken) && lk_ghist == $past(up_ghist)) |->
      lk_gctr == (($past(up_gctr) == 2'd3) ? 2'd3 : $past(up_gctr) + 2'd1));

  p_glob_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(up_valid && !up_taken) && lk_ghist == $past(up_ghist)) |->
      lk_gctr == (($past(up_gctr) == 2'd0) ? 2'd0 : $past(up_gctr) - 2'd1));

  p_lhist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(up_valid) && lk_lht_idx == $past(up_lht_idx)) |->
      lk_lhist == {$past(up_lhist[LHIST_W-2:0]), $past(up_taken)});

  p_chooser_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(up_valid && (up_glob_pred == up_loc_pred)) && lk_ghist == $past(up_ghist)) |->
      lk_cctr == $past(up_cctr));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!up_valid) && lk_ghist == $past(up_ghist)) |->
      (lk_gctr == $past(up_gctr)) && (lk_cctr == $past(up_cctr)));
endmodule

bind tournament_bp tbp_checker #(
  .GHIST_W(GHIST_W), .LHT_W(LHT_W), .LHIST_W(LHIST_W)
) u_tbp_chk (
  .clk(clk), .rst_n(rst_n), .lk_ghist(lk_ghist),
  .lk_taken(lk_taken), .lk_glob_pred(lk_glob_pred), .lk_loc_pred(lk_loc_pred),
  .up_valid(up_valid), .up_ghist(up_ghist), .up_taken(up_taken),
  .up_glob_pred(up_glob_pred), .up_loc_pred(up_loc_pred),
  .lk_lht_idx(lk_lht_idx), .up_lht_idx(up_lht_idx),
  .lk_lhist(lk_lhist), .up_lhist(up_lhist),
  .lk_gctr(lk_gctr), .up_gctr(up_gctr), .lk_cctr(lk_cctr), .up_cctr(up_cctr)
);

// File: tb/tournament_bp_tb.sv
`timescale 1ns/1ps
module tournament_bp_tb_top;
  localparam int PC_W    = 32;
  localparam int GHIST_W = 8;
  localparam int LHT_W   = 6;
  localparam int LHIST_W = 8;
  localparam int LPRED_W = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [PC_W-1:0]    lk_pc = '0;
  logic [GHIST_W-1:0] lk_ghist = '0;
  logic               lk_taken, lk_glob_pred, lk_loc_pred;
  logic               up_valid = 1'b0;
  logic [PC_W-1:0]    up_pc = '0;
  logic [GHIST_W-1:0] up_ghist = '0;
  logic               up_taken = 1'b0, up_glob_pred = 1'b0, up_loc_pred = 1'b0;

  always #4 clk = ~clk;

  tournament_bp #(.PC_W(PC_W), .GHIST_W(GHIST_W), .LHT_W(LHT_W),
                  .LHIST_W(LHIST_W), .LPRED_W(LPRED_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_ghist(lk_ghist),
    .lk_taken(lk_taken), .lk_glob_pred(lk_glob_pred), .lk_loc_pred(lk_loc_pred),
    .up_valid(up_valid), .up_pc(up_pc), .up_ghist(up_ghist), .up_taken(up_taken),
    .up_glob_pred(up_glob_pred), .up_loc_pred(up_loc_pred)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string phase = "R1";

  // Behavioural reference state.
  int gm [int];
  int lm [int];
  int cm [int];
  int hm [int];

  function automatic int step(int c, bit up);
    if (up) return (c >= 3) ? 3 : c + 1;
    return (c <= 0) ? 0 : c - 1;
  endfunction

  function automatic int rd(ref int t [int], input int k, input int dflt);
    return t.exists(k) ? t[k] : dflt;
  endfunction

  function automatic int lht_of(logic [PC_W-1:0] pc);
    return (int'(pc) >> 2) % (1 << LHT_W);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s (%s) actual=%0b expected=%0b at %0t", req, phase, act, exp, $time);
    end
  endtask

  task automatic cycle(logic [PC_W-1:0] lpc, int lgh, bit uv, logic [PC_W-1:0] upc,
                       int ugh, bit ut, bit ugp, bit ulp);
    int h, li;
    bit eg, el, et;
    @(negedge clk);
    lk_pc = lpc; lk_ghist = GHIST_W'(lgh);
    up_valid = uv; up_pc = upc; up_ghist = GHIST_W'(ugh);
    up_taken = ut; up_glob_pred = ugp; up_loc_pred = ulp;
    #1;
    h  = rd(hm, lht_of(lpc), 0);
    li = h % (1 << LPRED_W);
    eg = rd(gm, lgh, 1) >= 2;
    el = rd(lm, li, 1) >= 2;
    et = (rd(cm, lgh, 1) >= 2) ? eg : el;
    check("R2", lk_glob_pred, eg);
    check("R3", lk_loc_pred, el);
    check("R6", lk_taken, et);
    if (uv) begin
      gm[ugh] = step(rd(gm, ugh, 1), ut);
      h = rd(hm, lht_of(upc), 0);
      lm[h % (1 << LPRED_W)] = step(rd(lm, h % (1 << LPRED_W), 1), ut);
      if (ugp != ulp) cm[ugh] = step(rd(cm, ugh, 1), ugp == ut);
      hm[lht_of(upc)] = ((h << 1) | int'(ut)) % (1 << LHIST_W);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state, all predictions not-taken.
    phase = "R1";
    for (int i = 0; i < 6; i++) cycle(32'h1000 + 32'(i*4), i*37, 0, 0, 0, 0, 0, 0);

    // R4: global counter climbs and saturates, then falls and saturates.
    phase = "R4";
    for (int i = 0; i < 5; i++) cycle(32'h0, 5, 1, 32'h100, 5, 1, 0, 0);
    for (int i = 0; i < 6; i++) cycle(32'h0, 5, 1, 32'h100, 5, 0, 0, 0);

    // R5: local history shift and local counter training for one PC.
    phase = "R5";
    for (int i = 0; i < 12; i++) cycle(32'h40, 9, 1, 32'h40, 9, 1, 1, 1);
    for (int i = 0; i < 12; i++) cycle(32'h40, 9, 1, 32'h40, 9, i[0], 0, 0);

    // R7: chooser moves only on disagreement, toward the right component.
    phase = "R7";
    for (int i = 0; i < 4; i++) cycle(32'h80, 20, 1, 32'h80, 20, 1, 1, 1);
    for (int i = 0; i < 4; i++) cycle(32'h80, 20, 1, 32'h84, 20, 1, 1, 0);
    for (int i = 0; i < 4; i++) cycle(32'h80, 20, 1, 32'h84, 20, 0, 1, 0);

    // R8: same-cycle lookup and update of the same entries.
    phase = "R8";
    for (int i = 0; i < 6; i++) cycle(32'hC0, 33, 1, 32'hC0, 33, 1, i[1], i[0]);

    // R9: idle update fields must not touch any table.
    phase = "R9";
    for (int i = 0; i < 6; i++) cycle(32'hC0, 33, 0, 32'hC0, 33, i[0], 1, 0);

    // Mixed traffic over a small set of branches and histories.
    phase = "mix";
    for (int i = 0; i < 3000; i++) begin
      int lh, uh;
      logic [PC_W-1:0] lp, upc;
      lh  = $urandom_range(0, 15);
      uh  = $urandom_range(0, 15);
      lp  = {$urandom_range(0, 255), 2'b00} & 32'h0000_003C;
      upc = {$urandom_range(0, 255), 2'b00} & 32'h0000_003C;
      if ($urandom_range(0, 3) == 0) upc = lp;
      cycle(lp | 32'h4000_0000, lh, $urandom_range(0, 3) != 0, upc, uh,
            $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule